// File: doc/BRIEF.md
# Message-Signalled Interrupt Vector Dispatcher

This block sits inside a PCIe-style endpoint and turns device-side interrupt requests into memory-write messages. It keeps a table with one entry per vector. Each entry holds a 64-bit target address, a 32-bit payload and a mask bit. Beside the table it keeps a pending bitmap and two capability control bits: a global enable and a function-wide mask. Software reaches the table, the pending bitmap and the control word through a simple 32-bit register port with byte enables. Reads are combinational.

Device logic raises a request by giving a vector number. It also declares vectors in use or out of use, which moves a per-vector use counter. When a request arrives for a vector that is not masked, the block queues a message. The message leaves on a valid/ready output that carries the entry's address and payload. When the vector is masked, the block records a pending bit instead. When a masking condition lifts, either per entry or function-wide, every vector that has a pending bit is replayed. Queued messages leave one per handshake, the lowest vector number first.

Top module: `msix_dispatch`

## Requirements
- R1: The function-wide mask is active when the enable bit is 0 or the mask-all bit is 1. A vector is masked when the function-wide mask is active or bit 0 of its entry control word is 1.
- R2: A request for an unmasked vector produces one message. The message carries the address {upper word, lower word} and the payload of that entry, with msg_vec set to the vector number. The message is held stable until msg_ready is seen high.
- R3: A request for a masked vector sets that vector's pending bit and produces no message.
- R4: When a vector goes from masked to unmasked with its pending bit set, the pending bit clears and the vector's message is sent. A transition from unmasked to masked sends nothing.
- R5: A change of the function-wide mask re-evaluates every vector. Clearing mask-all replays each pending vector whose own mask bit is 0.
- R6: The pending bit of vector v is bit v mod 32 of the pending word at PBA_BASE + 4*(v div 32), which is byte v div 8, bit v mod 8. The pending region is ceil(NUM_VEC/64)*8 bytes long. Bits above the last vector read 0. The region is read-only, and writes to it are ignored.
- R7: The table and the pending region accept only full 4-byte accesses, with reg_be = 4'hF and an address aligned to 4 bytes. Other writes there are ignored and other reads return 0. Reads of an address outside the table, the pending region and the control word return 0.
- R8: A request is dropped, with neither message nor pending bit, when its vector number is NUM_VEC or larger, or when that vector's use count is zero.
- R9: A use adds one to a vector's count and an unuse subtracts one. An unuse at zero has no effect. When a count returns to zero, that vector's pending bit clears.
- R10: After reset, enable and mask-all are 0. Every address, payload and pending bit is 0. Every entry mask bit is 1, and every use count is 0.
- R11: The control word at CTL_ADDR reads bits 10:0 = NUM_VEC-1 (read-only), bit 14 = mask-all and bit 15 = enable. The two flags are written only when reg_be[1] is set.
- R12: intx_clr pulses for exactly one cycle after a control write with reg_be[1] set that leaves enable at 1.
- R13: When several vectors are queued, messages leave one per accepted handshake, in increasing vector number.
- R14: An entry is 16 bytes: lower address at offset 0, upper address at 4, payload at 8 and control word at 12. Only bit 0 of the control word is stored; the other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; reg_rdata is 0 when low |
| reg_addr | input | AW | Byte address |
| reg_be | input | 4 | Byte enables |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data (combinational) |
| req_valid | input | 1 | Interrupt request strobe |
| req_vec | input | 11 | Requested vector number |
| use_valid | input | 1 | Use-count update strobe |
| use_vec | input | 11 | Vector whose use count changes |
| use_up | input | 1 | 1 = use, 0 = unuse |
| msg_valid | output | 1 | Message available |
| msg_ready | input | 1 | Consumer accepts the message |
| msg_addr | output | 64 | Message target address |
| msg_data | output | 32 | Message payload |
| msg_vec | output | 11 | Vector the message belongs to |
| intx_clr | output | 1 | Pulse to deassert the legacy wired interrupt |

## Verification
The bench builds the block with NUM_VEC = 12, a count that is not a power of two. Vector 10 then sits in the second pending byte, and the pending region holds a second word that must read 0. Vector numbers from 12 upward become reachable as out-of-range requests. The default use-count width of 4 bits is kept, which leaves room to stack several uses on one vector and unwind them one at a time.

// File: rtl/msix_pkg.sv
package msix_pkg;

  // width of vector numbers and of the table-size field
  localparam int SIZE_W = 11;

  typedef enum logic [1:0] {
    W_ADDR_LO = 2'd0,
    W_ADDR_HI = 2'd1,
    W_DATA    = 2'd2,
    W_VCTL    = 2'd3
  } entry_word_e;

  // pending region length in bytes: vector count rounded up to 64 bits
  function automatic int pba_bytes(int n);
    return ((n + 63) / 64) * 8;
  endfunction

  // function-wide mask from the two control flags
  function automatic logic fn_masked(logic en, logic all);
    return !en || all;
  endfunction

  // control word image
  function automatic logic [31:0] ctl_image(logic en, logic all, int n);
    return {16'b0, en, all, 3'b0, SIZE_W'(n - 1)};
  endfunction

endpackage

// File: rtl/msix_vec_table.sv
module msix_vec_table
  import msix_pkg::*;
#(
  parameter int NUM_VEC = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [SIZE_W-1:0]  wr_vec,
  input  entry_word_e        wr_word,
  input  logic [31:0]        wr_data,
  input  logic [SIZE_W-1:0]  rd_vec,
  input  entry_word_e        rd_word,
  output logic [31:0]        rd_data,
  input  logic [SIZE_W-1:0]  mv_vec,
  output logic [63:0]        mv_addr,
  output logic [31:0]        mv_data,
  output logic [NUM_VEC-1:0] vmask_q,
  output logic [NUM_VEC-1:0] vmask_d
);

  localparam int VI_W = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1;

  logic [NUM_VEC-1:0][31:0] lo_all, hi_all, dat_all;

  for (genvar v = 0; v < NUM_VEC; v++) begin : g_ent
    logic [31:0] lo_q, hi_q, dat_q;
    logic        msk_q;
    logic        hit;
    assign hit = wr_en && (wr_vec == SIZE_W'(v));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lo_q  <= '0;
        hi_q  <= '0;
        dat_q <= '0;
        msk_q <= 1'b1;
      end else if (hit) begin
        case (wr_word)
          W_ADDR_LO: lo_q  <= wr_data;
          W_ADDR_HI: hi_q  <= wr_data;
          W_DATA:    dat_q <= wr_data;
          W_VCTL:    msk_q <= wr_data[0];
        endcase
      end
    end

    assign lo_all[v]  = lo_q;
    assign hi_all[v]  = hi_q;
    assign dat_all[v] = dat_q;
    assign vmask_q[v] = msk_q;
    assign vmask_d[v] = (hit && wr_word == W_VCTL) ? wr_data[0] : msk_q;
  end

  logic [VI_W-1:0] ridx, midx;
  assign ridx = (rd_vec < SIZE_W'(NUM_VEC)) ? rd_vec[VI_W-1:0] : '0;
  assign midx = (mv_vec < SIZE_W'(NUM_VEC)) ? mv_vec[VI_W-1:0] : '0;

  always_comb begin
    case (rd_word)
      W_ADDR_LO: rd_data = lo_all[ridx];
      W_ADDR_HI: rd_data = hi_all[ridx];
      W_DATA:    rd_data = dat_all[ridx];
      default:   rd_data = {31'b0, vmask_q[ridx]};
    endcase
  end

  assign mv_addr = {hi_all[midx], lo_all[midx]};
  assign mv_data = dat_all[midx];

endmodule

// File: rtl/msix_use_cnt.sv
module msix_use_cnt
  import msix_pkg::*;
#(
  parameter int NUM_VEC = 8,
  parameter int CNT_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               use_valid,
  input  logic [SIZE_W-1:0]  use_vec,
  input  logic               use_up,
  output logic [NUM_VEC-1:0] used,
  output logic [NUM_VEC-1:0] zeroed
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  for (genvar v = 0; v < NUM_VEC; v++) begin : g_cnt
    logic [CNT_W-1:0] cnt_q;
    logic             sel;
    assign sel = use_valid && (use_vec == SIZE_W'(v));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            cnt_q <= '0;
      else if (sel && use_up && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
      else if (sel && !use_up && cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
    end

    assign used[v]   = (cnt_q != '0);
    assign zeroed[v] = sel && !use_up && (cnt_q == CNT_W'(1));
  end

endmodule

// File: rtl/msix_pend_ctl.sv
module msix_pend_ctl
  import msix_pkg::*;
#(
  parameter int NUM_VEC = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [SIZE_W-1:0]  req_vec,
  input  logic [NUM_VEC-1:0] used,
  input  logic [NUM_VEC-1:0] zeroed,
  input  logic [NUM_VEC-1:0] masked_cur,
  input  logic [NUM_VEC-1:0] masked_nxt,
  input  logic               take,
  input  logic [SIZE_W-1:0]  take_vec,
  output logic [NUM_VEC-1:0] pend_q,
  output logic [NUM_VEC-1:0] sendq_q,
  output logic               pick_valid,
  output logic [SIZE_W-1:0]  pick_vec
);

  logic [NUM_VEC-1:0] req_oh, take_oh, unmask, replay;
  logic [NUM_VEC-1:0] pend_a, sq_a, pend_d, sq_d, elig;

  always_comb begin
    for (int v = 0; v < NUM_VEC; v++) begin
      req_oh[v]  = req_valid && (req_vec == SIZE_W'(v)) && used[v];
      take_oh[v] = take && (take_vec == SIZE_W'(v));
    end
    unmask = masked_cur & ~masked_nxt;
    pend_a = pend_q | (req_oh & masked_cur);
    sq_a   = sendq_q | (req_oh & ~masked_cur);
    replay = unmask & pend_a;
    // queued but now masked entries fall back to pending
    pend_d = ((pend_a & ~replay) | (sq_a & masked_nxt)) & ~zeroed;
    sq_d   = ((sq_a | replay) & ~masked_nxt) & ~take_oh & ~zeroed;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= '0;
      sendq_q <= '0;
    end else begin
      pend_q  <= pend_d;
      sendq_q <= sq_d;
    end
  end

  // lowest queued vector that stays unmasked
  always_comb begin
    elig       = sendq_q & ~masked_nxt;
    pick_valid = |elig;
    pick_vec   = '0;
    for (int v = NUM_VEC - 1; v >= 0; v--) begin
      if (elig[v]) pick_vec = SIZE_W'(v);
    end
  end

endmodule

// File: rtl/msix_dispatch.sv
module msix_dispatch
  import msix_pkg::*;
#(
  parameter int NUM_VEC  = 8,
  parameter int CNT_W    = 4,
  parameter int AW       = 12,
  parameter int PBA_BASE = 'h800,
  parameter int CTL_ADDR = 'hC00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [AW-1:0]     reg_addr,
  input  logic [3:0]        reg_be,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              req_valid,
  input  logic [SIZE_W-1:0] req_vec,
  input  logic              use_valid,
  input  logic [SIZE_W-1:0] use_vec,
  input  logic              use_up,
  output logic              msg_valid,
  input  logic              msg_ready,
  output logic [63:0]       msg_addr,
  output logic [31:0]       msg_data,
  output logic [SIZE_W-1:0] msg_vec,
  output logic              intx_clr
);

  localparam int            PBA_BYTES = pba_bytes(NUM_VEC);
  localparam int            PBA_WORDS = PBA_BYTES / 4;
  localparam logic [AW-1:0] TBL_END   = AW'(NUM_VEC * 16);
  localparam logic [AW-1:0] PBA_LO    = AW'(PBA_BASE);
  localparam logic [AW-1:0] PBA_HI    = AW'(PBA_BASE + PBA_BYTES);
  localparam logic [AW-1:0] CTL_A     = AW'(CTL_ADDR);

  // ---------------- address decode ----------------
  logic full, tbl_hit, pba_hit, ctl_hit, ctl_wr, tbl_wr;
  logic [SIZE_W-1:0] tbl_vec;
  entry_word_e       tbl_word;
  logic [AW-3:0]     pba_widx;

  assign full     = (reg_be == 4'hF) && (reg_addr[1:0] == 2'b00);
  assign tbl_hit  = full && (reg_addr < TBL_END);
  assign pba_hit  = full && (reg_addr >= PBA_LO) && (reg_addr < PBA_HI);
  assign ctl_hit  = (reg_addr == CTL_A);
  assign ctl_wr   = reg_wr && ctl_hit && reg_be[1];
  assign tbl_wr   = reg_wr && tbl_hit;
  assign tbl_vec  = SIZE_W'(reg_addr[AW-1:4]);
  assign tbl_word = entry_word_e'(reg_addr[3:2]);
  assign pba_widx = reg_addr[AW-1:2] - PBA_LO[AW-1:2];

  // ---------------- capability control ----------------
  logic en_q, all_q, en_d, all_d, fn_cur, fn_nxt;
  assign en_d   = ctl_wr ? reg_wdata[15] : en_q;
  assign all_d  = ctl_wr ? reg_wdata[14] : all_q;
  assign fn_cur = fn_masked(en_q, all_q);
  assign fn_nxt = fn_masked(en_d, all_d);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      all_q    <= 1'b0;
      intx_clr <= 1'b0;
    end else begin
      en_q     <= en_d;
      all_q    <= all_d;
      intx_clr <= ctl_wr && reg_wdata[15];
    end
  end

  // ---------------- submodules ----------------
  logic [31:0]        tbl_rd;
  logic [63:0]        mv_addr;
  logic [31:0]        mv_data;
  logic [NUM_VEC-1:0] vmask_q, vmask_d, used, zeroed;
  logic [NUM_VEC-1:0] masked_cur, masked_nxt, pend_q, sendq_q;
  logic               pick_valid, load;
  logic [SIZE_W-1:0]  pick_vec;

  msix_vec_table #(.NUM_VEC(NUM_VEC)) u_table (
    .clk, .rst_n,
    .wr_en(tbl_wr), .wr_vec(tbl_vec), .wr_word(tbl_word), .wr_data(reg_wdata),
    .rd_vec(tbl_vec), .rd_word(tbl_word), .rd_data(tbl_rd),
    .mv_vec(pick_vec), .mv_addr(mv_addr), .mv_data(mv_data),
    .vmask_q(vmask_q), .vmask_d(vmask_d)
  );

  msix_use_cnt #(.NUM_VEC(NUM_VEC), .CNT_W(CNT_W)) u_use (
    .clk, .rst_n,
    .use_valid, .use_vec, .use_up,
    .used(used), .zeroed(zeroed)
  );

  assign masked_cur = vmask_q | {NUM_VEC{fn_cur}};
  assign masked_nxt = vmask_d | {NUM_VEC{fn_nxt}};

  msix_pend_ctl #(.NUM_VEC(NUM_VEC)) u_pend (
    .clk, .rst_n,
    .req_valid, .req_vec,
    .used(used), .zeroed(zeroed),
    .masked_cur(masked_cur), .masked_nxt(masked_nxt),
    .take(load), .take_vec(pick_vec),
    .pend_q(pend_q), .sendq_q(sendq_q),
    .pick_valid(pick_valid), .pick_vec(pick_vec)
  );

  // ---------------- message output stage ----------------
  assign load = pick_valid && (!msg_valid || msg_ready);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msg_valid <= 1'b0;
      msg_addr  <= '0;
      msg_data  <= '0;
      msg_vec   <= '0;
    end else if (load) begin
      msg_valid <= 1'b1;
      msg_addr  <= mv_addr;
      msg_data  <= mv_data;
      msg_vec   <= pick_vec;
    end else if (msg_ready) begin
      msg_valid <= 1'b0;
    end
  end

  // ---------------- read mux ----------------
  logic [PBA_WORDS*32-1:0] pend_pad;
  logic [31:0]             pword;

  always_comb begin
    pend_pad                = '0;
    pend_pad[NUM_VEC-1:0]   = pend_q;
    pword                   = '0;
    for (int w = 0; w < PBA_WORDS; w++) begin
      if (pba_widx == (AW-2)'(w)) pword = pend_pad[w*32 +: 32];
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      if (tbl_hit)      reg_rdata = tbl_rd;
      else if (pba_hit) reg_rdata = pword;
      else if (ctl_hit) reg_rdata = ctl_image(en_q, all_q, NUM_VEC);
    end
  end

endmodule

// File: rtl/msix_dispatch_chk.sv
module msix_dispatch_chk
  import msix_pkg::*;
#(
  parameter int NUM_VEC  = 8,
  parameter int AW       = 12,
  parameter int CTL_ADDR = 'hC00
) (
  input logic               clk,
  input logic               rst_n,
  input logic               reg_wr,
  input logic [AW-1:0]      reg_addr,
  input logic [3:0]         reg_be,
  input logic               msg_valid,
  input logic               msg_ready,
  input logic [63:0]        msg_addr,
  input logic [31:0]        msg_data,
  input logic [SIZE_W-1:0]  msg_vec,
  input logic               intx_clr,
  input logic               ctl_en,
  input logic [NUM_VEC-1:0] pend_q,
  input logic [NUM_VEC-1:0] sendq_q,
  input logic [NUM_VEC-1:0] masked_cur
);

  // R2: an offered message stays put until accepted
  p_msg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_addr) &&
                                $stable(msg_data) && $stable(msg_vec));

  // R8: only configured vectors ever leave
  p_msg_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> msg_vec < SIZE_W'(NUM_VEC));

  // R4: no pending bit survives on an unmasked vector
  p_pend_unmasked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q & ~masked_cur) == '0);

  // R3: a vector is never both pending and queued for delivery
  p_pend_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q & sendq_q) == '0);

  // R12: the INTx clear pulse follows a control write leaving enable set
  p_intx_r12: assert property (@(posedge clk) disable iff (!rst_n)
    intx_clr |-> $past(reg_wr && reg_be[1] && reg_addr == AW'(CTL_ADDR)) && ctl_en);

endmodule

bind msix_dispatch msix_dispatch_chk #(
  .NUM_VEC(NUM_VEC), .AW(AW), .CTL_ADDR(CTL_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_be(reg_be),
  .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_addr(msg_addr),
  .msg_data(msg_data), .msg_vec(msg_vec), .intx_clr(intx_clr),
  .ctl_en(en_q), .pend_q(pend_q), .sendq_q(sendq_q), .masked_cur(masked_cur)
);

// File: tb/msix_dispatch_bench.sv
module msix_dispatch_bench;

  localparam int NV  = 12;
  localparam int AW  = 12;
  localparam logic [11:0] PBA = 12'h800;
  localparam logic [11:0] CTL = 12'hC00;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 0, reg_rd = 0, req_valid = 0, use_valid = 0, use_up = 0, msg_ready = 0;
  logic [AW-1:0] reg_addr = '0;
  logic [3:0]    reg_be = '0;
  logic [31:0]   reg_wdata = '0, reg_rdata;
  logic [10:0]   req_vec = '0, use_vec = '0, msg_vec;
  logic          msg_valid, intx_clr;
  logic [63:0]   msg_addr;
  logic [31:0]   msg_data;

  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  msix_dispatch #(.NUM_VEC(NV), .CNT_W(4), .AW(AW), .PBA_BASE('h800), .CTL_ADDR('hC00))
  u_msix_dispatch (
    .clk, .rst_n, .reg_wr, .reg_rd, .reg_addr, .reg_be, .reg_wdata, .reg_rdata,
    .req_valid, .req_vec, .use_valid, .use_vec, .use_up,
    .msg_valid, .msg_ready, .msg_addr, .msg_data, .msg_vec, .intx_clr
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d, logic [3:0] be = 4'hF);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d; reg_be = be;
    @(negedge clk);
    reg_wr = 0; reg_be = 4'h0;
  endtask

  task automatic rd_chk(string tag, logic [AW-1:0] a, logic [31:0] exp, logic [3:0] be = 4'hF);
    reg_rd = 1; reg_addr = a; reg_be = be;
    #1;
    chk(tag, 64'(reg_rdata), 64'(exp));
    reg_rd = 0; reg_be = 4'h0;
  endtask

  task automatic req(int v);
    @(negedge clk);
    req_valid = 1; req_vec = 11'(v);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic use_op(int v, logic up);
    @(negedge clk);
    use_valid = 1; use_vec = 11'(v); use_up = up;
    @(negedge clk);
    use_valid = 0;
  endtask

  function automatic logic [63:0] exp_addr(int v);
    return {32'(v), 32'h1000_0000 + 32'(v * 16)};
  endfunction

  task automatic expect_msg(string tag, int v);
    @(negedge clk);
    chk({tag, " valid"}, 64'(msg_valid), 64'd1);
    chk({tag, " vec"},   64'(msg_vec), 64'(v));
    chk({tag, " addr"},  msg_addr, exp_addr(v));
    chk({tag, " data"},  64'(msg_data), 64'(32'hD000 + v));
    msg_ready = 1;
    @(negedge clk);
    msg_ready = 0;
  endtask

  task automatic expect_idle(string tag);
    repeat (3) @(negedge clk);
    chk(tag, 64'(msg_valid), 64'd0);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset;
    chk("R10 msg_valid", 64'(msg_valid), 64'd0);
    chk("R10 intx", 64'(intx_clr), 64'd0);
    rd_chk("R10 R11 ctl word", CTL, 32'h0000_000B);
    rd_chk("R10 entry mask", 12'h03C, 32'h1);
    rd_chk("R10 entry data", 12'h038, 32'h0);
    rd_chk("R10 pending", PBA, 32'h0);
  endtask

  task automatic t_setup;
    for (int v = 0; v < NV; v++) begin
      if (v != 7) use_op(v, 1'b1);
      wr(12'(v * 16),      32'h1000_0000 + 32'(v * 16));
      wr(12'(v * 16 + 4),  32'(v));
      wr(12'(v * 16 + 8),  32'hD000 + 32'(v));
      wr(12'(v * 16 + 12), 32'h0);
    end
    rd_chk("R14 lower addr", 12'h040, 32'h1000_0040);
    rd_chk("R14 payload", 12'h048, 32'hD004);
    wr(12'h04C, 32'hFFFF_FFFF);
    rd_chk("R14 ctl bit0 only", 12'h04C, 32'h1);
    wr(12'h04C, 32'h0);
    rd_chk("R7 outside", 12'h400, 32'h0);
    rd_chk("R7 partial read", 12'h040, 32'h0, 4'h1);
    rd_chk("R6 pending word1", PBA + 12'h4, 32'h0);
    rd_chk("R7 past pending", PBA + 12'h8, 32'h0);
  endtask

  task automatic t_enable;
    wr(CTL, 32'h0000_8000);
    chk("R12 intx pulse", 64'(intx_clr), 64'd1);
    @(negedge clk);
    chk("R12 intx one cycle", 64'(intx_clr), 64'd0);
    rd_chk("R11 ctl enabled", CTL, 32'h0000_800B);
  endtask

  task automatic t_deliver;
    req(3);
    @(negedge clk);
    chk("R2 offered", 64'(msg_valid), 64'd1);
    @(negedge clk);
    chk("R2 held", 64'(msg_valid), 64'd1);
    expect_msg("R2 deliver", 3);
    expect_idle("R2 single message");
  endtask

  task automatic t_drop;
    req(7);
    expect_idle("R8 unused vector");
    req(12);
    expect_idle("R8 out of range");
    rd_chk("R8 no pending", PBA, 32'h0);
  endtask

  task automatic t_masked;
    wr(12'h05C, 32'h1);
    req(5);
    expect_idle("R3 masked no message");
    rd_chk("R3 pending set", PBA, 32'h20);
    wr(PBA, 32'hFFFF_FFFF);
    rd_chk("R6 pending read-only", PBA, 32'h20);
    wr(12'h05C, 32'h0, 4'h3);
    rd_chk("R7 partial write ignored", 12'h05C, 32'h1);
    expect_idle("R7 still masked");
    wr(12'h05C, 32'h0);
    expect_msg("R4 replay on unmask", 5);
    rd_chk("R4 pending cleared", PBA, 32'h0);
    wr(12'h05C, 32'h1);
    expect_idle("R4 masking sends nothing");
    wr(12'h05C, 32'h0);
    expect_idle("R4 nothing pending");
  endtask

  task automatic t_fnmask;
    wr(12'h0AC, 32'h1);
    req(10);
    rd_chk("R6 vector 10 in byte 1", PBA, 32'h400);
    wr(CTL, 32'h0000_C000);
    req(9);
    req(1);
    expect_idle("R1 mask-all holds");
    rd_chk("R5 pending under mask-all", PBA, 32'h602);
    wr(CTL, 32'h0000_8000);
    expect_msg("R13 lowest first", 1);
    expect_msg("R5 R13 second", 9);
    expect_idle("R5 entry-masked stays");
    rd_chk("R5 remaining pending", PBA, 32'h400);
  endtask

  task automatic t_unuse;
    use_op(10, 1'b0);
    rd_chk("R9 count zero clears pending", PBA, 32'h0);
    use_op(10, 1'b0);
    wr(12'h0AC, 32'h0);
    expect_idle("R9 nothing replayed");
    req(10);
    expect_idle("R9 zero count drops");
    use_op(11, 1'b1);
    use_op(11, 1'b0);
    req(11);
    expect_msg("R9 count still positive", 11);
  endtask

  task automatic t_disable;
    wr(CTL, 32'h0);
    chk("R12 no pulse when disabled", 64'(intx_clr), 64'd0);
    req(2);
    expect_idle("R1 disabled masks");
    rd_chk("R1 pending on disable", PBA, 32'h4);
  endtask

  initial begin
    #(4 * 100000);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_setup();
    t_enable();
    t_deliver();
    t_drop();
    t_masked();
    t_fnmask();
    t_unuse();
    t_disable();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule